// File: doc/BRIEF.md
# Sparse Bank Access Scheduler

This block accepts vectors of pointer-indexed memory operations, one operation per lane, and carries them out against a banked on-chip store. Lanes of a random-access vector often point at the same bank. Instead of stalling the whole vector on such a conflict, the scheduler keeps several vectors in an issue queue. Every cycle it chooses a conflict-free set of lane-to-bank pairings from all pending work. The low address bits choose the bank, and the remaining upper bits choose the word inside that bank.

Every pending entry marks its bank in a lane-by-bank request matrix. A separable allocator with an input-first pass and several rounds matches lanes to banks. Inside each matched lane, the entry nearest the queue head is the one issued. Each bank owns a two-stage read-modify-write pipe. The pipe returns the value the word held before the operation and forwards its result to an immediately following access to the same word. Replies are steered back to the slot and lane they came from. A vector leaves the queue in arrival order once all of its active lanes have finished.

Top module: `sparse_bank_sched`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every memory word reads as 0.
- R2: An address maps to bank addr[log2(BANKS)-1:0] and to word addr[AW-1:log2(BANKS)]. Different addresses never alias.
- R3: The per-lane op codes are 0 read, 1 write (store the operand), 2 add, 3 subtract (old minus operand), 4 AND, 5 OR and 6 XOR. Every op returns the word's value from before the operation.
- R4: Operations from one lane take effect on memory in the order their vectors were accepted.
- R5: In any cycle, each lane receives at most one bank grant and each bank receives at most one lane grant.
- R6: When every lane of a vector targets the same bank, all of its operations still complete, each on its own word.
- R7: Back-to-back updates to the same word, including updates from different lanes and vectors, are never lost.
- R8: out_valid is asserted only when the oldest held vector has completed all of its active lanes. Vectors leave in acceptance order, and each reply sits in the lane that issued it.
- R9: A lane whose in_lane_vld bit is 0 is not executed and leaves memory unchanged. Its out_lane_vld bit is 0 and its out_data is 0.
- R10: in_ready is 0 exactly when DEPTH vectors are held. While in_ready is 0, an offered vector is not taken.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offered request vector is valid |
| in_ready | output | 1 | Issue queue can accept a vector |
| in_lane_vld | input | LANES | Per-lane active mask |
| in_addr | input | LANES x AW | Per-lane word address |
| in_op | input | LANES x 3 | Per-lane operation code |
| in_data | input | LANES x DW | Per-lane operand |
| out_valid | output | 1 | Oldest vector is complete |
| out_ready | input | 1 | Consumer takes the completed vector |
| out_lane_vld | output | LANES | Active mask of the delivered vector |
| out_data | output | LANES x DW | Per-lane prior memory value |

## Verification
The bench builds the block with 4 lanes, 4 banks, a queue depth of 4, 6-bit addresses and 16-bit data. At this size, a single vector can put every lane on one bank. A few back-to-back pushes fill the queue and expose the full condition. The same-lane ordering cases and the forwarding cases fit inside the queue, which keeps their expected prior values simple to work out.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_RD  = 3'd0,
        OP_WR  = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6
    } sbs_op_e;

    // New word value for an op; read and unknown codes keep the old value.
    function automatic logic [63:0] sbs_apply(sbs_op_e op, logic [63:0] old, logic [63:0] arg);
        case (op)
            OP_WR:   return arg;
            OP_ADD:  return old + arg;
            OP_SUB:  return old - arg;
            OP_AND:  return old & arg;
            OP_OR:   return old | arg;
            OP_XOR:  return old ^ arg;
            default: return old;
        endcase
    endfunction

endpackage

// File: rtl/sbs_alloc.sv
module sbs_alloc #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int ITERS = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0][BANKS-1:0]  req,
    output logic [LANES-1:0][BANKS-1:0]  gnt
);
    localparam int LB = $clog2(LANES);
    localparam int BB = $clog2(BANKS);
    localparam logic [LB-1:0] LMAX = LB'(LANES - 1);
    localparam logic [BB-1:0] BMAX = BB'(BANKS - 1);

    logic [LB-1:0] lptr;
    logic [BB-1:0] bptr;

    // Rotating start points keep the fixed-priority arbiters fair.
    always_ff @(posedge clk) begin
        if (rst) begin
            lptr <= '0;
            bptr <= '0;
        end else begin
            lptr <= (lptr == LMAX) ? '0 : lptr + 1'b1;
            bptr <= (bptr == BMAX) ? '0 : bptr + 1'b1;
        end
    end

    logic [LANES-1:0]            lane_m;
    logic [BANKS-1:0]            bank_m;
    logic [LANES-1:0][BANKS-1:0] pick;
    logic                        found;

    always_comb begin
        gnt    = '0;
        lane_m = '0;
        bank_m = '0;
        pick   = '0;
        found  = 1'b0;
        for (int it = 0; it < ITERS; it++) begin
            pick = '0;
            // input stage: each free lane names one free bank
            for (int l = 0; l < LANES; l++) begin
                found = 1'b0;
                if (!lane_m[l]) begin
                    for (int k = 0; k < BANKS; k++) begin
                        int bi;
                        bi = (int'(bptr) + k) % BANKS;
                        if (!found && req[l][bi] && !bank_m[bi]) begin
                            pick[l][bi] = 1'b1;
                            found       = 1'b1;
                        end
                    end
                end
            end
            // output stage: each free bank accepts one naming lane
            for (int b = 0; b < BANKS; b++) begin
                found = 1'b0;
                if (!bank_m[b]) begin
                    for (int k = 0; k < LANES; k++) begin
                        int li;
                        li = (int'(lptr) + k) % LANES;
                        if (!found && pick[li][b]) begin
                            gnt[li][b] = 1'b1;
                            lane_m[li] = 1'b1;
                            bank_m[b]  = 1'b1;
                            found      = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sbs_pick.sv
module sbs_pick #(
    parameter int DEPTH = 16,
    parameter int BANKS = 16
) (
    input  logic [$clog2(DEPTH)-1:0]              head,
    input  logic [DEPTH-1:0]                      pend,
    input  logic [DEPTH-1:0][$clog2(BANKS)-1:0]   bank,
    input  logic [BANKS-1:0]                      gnt_row,
    output logic [$clog2(DEPTH)-1:0]              sel_slot,
    output logic                                  sel_vld
);
    localparam int SB = $clog2(DEPTH);

    // Oldest entry is the one closest to the queue head.
    always_comb begin
        sel_slot = '0;
        sel_vld  = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s = (int'(head) + k) % DEPTH;
            if (!sel_vld && pend[s] && gnt_row[bank[s]]) begin
                sel_slot = SB'(s);
                sel_vld  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbs_bank.sv
module sbs_bank
    import sbs_pkg::*;
#(
    parameter int WB = 6,
    parameter int DW = 32,
    parameter int SB = 4,
    parameter int LB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [WB-1:0] in_word,
    input  sbs_op_e       in_op,
    input  logic [DW-1:0] in_arg,
    input  logic [SB-1:0] in_slot,
    input  logic [LB-1:0] in_lane,
    output logic          out_vld,
    output logic [SB-1:0] out_slot,
    output logic [LB-1:0] out_lane,
    output logic [DW-1:0] out_old
);
    localparam int WORDS = 1 << WB;

    logic [DW-1:0] mem [WORDS];

    logic          s_vld;
    logic [WB-1:0] s_word;
    sbs_op_e       s_op;
    logic [DW-1:0] s_arg;
    logic [SB-1:0] s_slot;
    logic [LB-1:0] s_lane;
    logic [DW-1:0] s_old;
    logic [DW-1:0] s_new;

    assign s_new = DW'(sbs_apply(s_op, 64'(s_old), 64'(s_arg)));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
            s_vld  <= 1'b0;
            s_word <= '0;
            s_op   <= OP_RD;
            s_arg  <= '0;
            s_slot <= '0;
            s_lane <= '0;
            s_old  <= '0;
        end else begin
            s_vld <= in_vld;
            if (in_vld) begin
                s_word <= in_word;
                s_op   <= in_op;
                s_arg  <= in_arg;
                s_slot <= in_slot;
                s_lane <= in_lane;
                // forward the value being written this edge to a same-word follower
                s_old  <= (s_vld && s_word == in_word) ? s_new : mem[in_word];
            end
            if (s_vld) mem[s_word] <= s_new;
        end
    end

    assign out_vld  = s_vld;
    assign out_slot = s_slot;
    assign out_lane = s_lane;
    assign out_old  = s_old;
endmodule

// File: rtl/sparse_bank_sched.sv
module sparse_bank_sched
    import sbs_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int ITERS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [LANES-1:0]            in_lane_vld,
    input  logic [LANES-1:0][AW-1:0]    in_addr,
    input  logic [LANES-1:0][2:0]       in_op,
    input  logic [LANES-1:0][DW-1:0]    in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [LANES-1:0]            out_lane_vld,
    output logic [LANES-1:0][DW-1:0]    out_data
);
    localparam int BB = $clog2(BANKS);
    localparam int WB = AW - BB;
    localparam int SB = $clog2(DEPTH);
    localparam int LB = $clog2(LANES);
    localparam logic [SB-1:0] SMAX = SB'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        sbs_op_e       op;
        logic [DW-1:0] arg;
    } ent_t;

    // issue / output queue state, one slot per vector
    ent_t                        q     [DEPTH][LANES];
    logic [DW-1:0]               res   [DEPTH][LANES];
    logic [DEPTH-1:0]            used;
    logic [DEPTH-1:0][LANES-1:0] lmask;
    logic [DEPTH-1:0][LANES-1:0] pend;
    logic [DEPTH-1:0][LANES-1:0] done;
    logic [SB-1:0]               head, tail;

    logic acc, deq;
    assign in_ready  = !used[tail];
    assign out_valid = used[head] && (&done[head]);
    assign acc       = in_valid && in_ready;
    assign deq       = out_valid && out_ready;

    always_comb begin
        out_lane_vld = lmask[head];
        for (int l = 0; l < LANES; l++) out_data[l] = res[head][l];
    end

    // request matrix from all pending entries
    logic [LANES-1:0][BANKS-1:0]         req;
    logic [LANES-1:0][DEPTH-1:0]         lane_pend;
    logic [LANES-1:0][DEPTH-1:0][BB-1:0] lane_bank;

    always_comb begin
        req = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < DEPTH; s++) begin
                lane_pend[l][s] = pend[s][l];
                lane_bank[l][s] = q[s][l].addr[BB-1:0];
                if (pend[s][l]) req[l][q[s][l].addr[BB-1:0]] = 1'b1;
            end
        end
    end

    logic [LANES-1:0][BANKS-1:0] alloc_gnt;

    sbs_alloc #(.LANES(LANES), .BANKS(BANKS), .ITERS(ITERS)) u_alloc (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (alloc_gnt)
    );

    logic [LANES-1:0][SB-1:0] pick_slot;
    logic [LANES-1:0]         pick_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sbs_pick #(.DEPTH(DEPTH), .BANKS(BANKS)) u_pick (
            .head     (head),
            .pend     (lane_pend[l]),
            .bank     (lane_bank[l]),
            .gnt_row  (alloc_gnt[l]),
            .sel_slot (pick_slot[l]),
            .sel_vld  (pick_vld[l])
        );
    end

    // forward crossbar: lanes to banks
    logic [BANKS-1:0]         bk_vld;
    logic [BANKS-1:0][WB-1:0] bk_word;
    sbs_op_e                  bk_op   [BANKS];
    logic [BANKS-1:0][DW-1:0] bk_arg;
    logic [BANKS-1:0][SB-1:0] bk_slot;
    logic [BANKS-1:0][LB-1:0] bk_lane;
    ent_t                     sel_e;

    always_comb begin
        sel_e = '0;
        for (int b = 0; b < BANKS; b++) begin
            bk_vld[b]  = 1'b0;
            bk_word[b] = '0;
            bk_op[b]   = OP_RD;
            bk_arg[b]  = '0;
            bk_slot[b] = '0;
            bk_lane[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (pick_vld[l] && alloc_gnt[l][b]) begin
                    sel_e      = q[pick_slot[l]][l];
                    bk_vld[b]  = 1'b1;
                    bk_word[b] = sel_e.addr[AW-1:BB];
                    bk_op[b]   = sel_e.op;
                    bk_arg[b]  = sel_e.arg;
                    bk_slot[b] = pick_slot[l];
                    bk_lane[b] = LB'(l);
                end
            end
        end
    end

    logic [BANKS-1:0]         rp_vld;
    logic [BANKS-1:0][SB-1:0] rp_slot;
    logic [BANKS-1:0][LB-1:0] rp_lane;
    logic [BANKS-1:0][DW-1:0] rp_old;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sbs_bank #(.WB(WB), .DW(DW), .SB(SB), .LB(LB)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (bk_vld[b]),
            .in_word  (bk_word[b]),
            .in_op    (bk_op[b]),
            .in_arg   (bk_arg[b]),
            .in_slot  (bk_slot[b]),
            .in_lane  (bk_lane[b]),
            .out_vld  (rp_vld[b]),
            .out_slot (rp_slot[b]),
            .out_lane (rp_lane[b]),
            .out_old  (rp_old[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used  <= '0;
            lmask <= '0;
            pend  <= '0;
            done  <= '0;
            head  <= '0;
            tail  <= '0;
            for (int s = 0; s < DEPTH; s++)
                for (int l = 0; l < LANES; l++) begin
                    res[s][l] <= '0;
                    q[s][l]   <= '0;
                end
        end else begin
            // issued entries leave the pending set
            for (int l = 0; l < LANES; l++)
                if (pick_vld[l]) pend[pick_slot[l]][l] <= 1'b0;
            // reverse crossbar: replies back to their slot and lane
            for (int b = 0; b < BANKS; b++)
                if (rp_vld[b]) begin
                    res[rp_slot[b]][rp_lane[b]]  <= rp_old[b];
                    done[rp_slot[b]][rp_lane[b]] <= 1'b1;
                end
            if (deq) begin
                used[head] <= 1'b0;
                head       <= (head == SMAX) ? '0 : head + 1'b1;
            end
            if (acc) begin
                used[tail]  <= 1'b1;
                lmask[tail] <= in_lane_vld;
                pend[tail]  <= in_lane_vld;
                done[tail]  <= ~in_lane_vld;
                for (int l = 0; l < LANES; l++) begin
                    q[tail][l]   <= ent_t'{addr: in_addr[l], op: sbs_op_e'(in_op[l]), arg: in_data[l]};
                    res[tail][l] <= '0;
                end
                tail <= (tail == SMAX) ? '0 : tail + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [LANES-1:0][DW-1:0]    out_data,
    input logic [LANES-1:0][BANKS-1:0] gnt
);
    localparam int OW = $clog2(DEPTH + 1);

    logic [OW-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else occ <= occ + OW'(in_valid && in_ready) - OW'(out_valid && out_ready);
    end

    // R10
    full_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready == (int'(occ) < DEPTH));

    // R8
    valid_needs_held_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> occ != '0);

    // R11
    hold_output_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    for (genvar l = 0; l < LANES; l++) begin : g_row
        // R5
        lane_one_grant_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt[l]));
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_col
        logic [LANES-1:0] col;
        always_comb for (int l = 0; l < LANES; l++) col[l] = gnt[l][b];
        // R5
        bank_one_grant_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
    end
endmodule

bind sparse_bank_sched sbs_chk #(
    .LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .gnt       (alloc_gnt)
);

// File: tb/sparse_bank_sched_tb.sv
`timescale 1ns/1ps
module sparse_bank_sched_tb;
    localparam int L  = 4;
    localparam int B  = 4;
    localparam int D  = 4;
    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [L-1:0]           in_lane_vld = '0;
    logic [L-1:0][AW-1:0]   in_addr = '0;
    logic [L-1:0][2:0]      in_op = '0;
    logic [L-1:0][DW-1:0]   in_data = '0;
    logic                   out_valid;
    logic                   out_ready = 1'b0;
    logic [L-1:0]           out_lane_vld;
    logic [L-1:0][DW-1:0]   out_data;

    sparse_bank_sched #(.LANES(L), .BANKS(B), .DEPTH(D), .AW(AW), .DW(DW), .ITERS(3)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_lane_vld(in_lane_vld), .in_addr(in_addr), .in_op(in_op), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_lane_vld(out_lane_vld), .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [L-1:0] m, input logic [L-1:0][AW-1:0] a,
                        input logic [L-1:0][2:0] o, input logic [L-1:0][DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_lane_vld = m; in_addr = a; in_op = o; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic pop(output logic [L-1:0] vm, output logic [L-1:0][DW-1:0] vd);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        vm = out_lane_vld;
        vd = out_data;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    logic [L-1:0]          gm;
    logic [L-1:0][DW-1:0]  gd;

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_dense();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        for (int l = 0; l < L; l++) begin a[l] = AW'(l); o[l] = 3'd1; d[l] = DW'(100 + l); end
        push(4'b1111, a, o, d);
        pop(gm, gd);
        check(gm == 4'b1111, "R8", "dense mask", int'(gm), 15);
        for (int l = 0; l < L; l++) check(gd[l] == 0, "R1", "fresh word prior value", int'(gd[l]), 0);
        for (int l = 0; l < L; l++) o[l] = 3'd0;
        push(4'b1111, a, o, '0);
        pop(gm, gd);
        for (int l = 0; l < L; l++) check(gd[l] == DW'(100 + l), "R2", "dense read lane", int'(gd[l]), 100 + l);
    endtask

    task automatic t_conflict();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        for (int l = 0; l < L; l++) begin a[l] = AW'(((l + 1) << 2) | 2); o[l] = 3'd1; d[l] = DW'(200 + l); end
        push(4'b1111, a, o, d);
        pop(gm, gd);
        for (int l = 0; l < L; l++) check(gd[l] == 0, "R6", "one-bank write prior", int'(gd[l]), 0);
        for (int l = 0; l < L; l++) o[l] = 3'd0;
        push(4'b1111, a, o, '0);
        pop(gm, gd);
        for (int l = 0; l < L; l++) check(gd[l] == DW'(200 + l), "R6", "one-bank readback", int'(gd[l]), 200 + l);
    endtask

    task automatic t_forward();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        for (int l = 0; l < L; l++) begin a[l] = AW'(5); o[l] = 3'd2; d[l] = DW'(l + 1); end
        for (int v = 0; v < 3; v++) push(4'b1111, a, o, d);
        for (int v = 0; v < 3; v++) pop(gm, gd);
        o[0] = 3'd0;
        push(4'b0001, a, o, '0);
        pop(gm, gd);
        check(gd[0] == 30, "R7", "same-word add total", int'(gd[0]), 30);
    endtask

    task automatic t_oldest();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        int exp_v [4] = '{0, 'h55, 'h55, 'h5A};
        a = '0; o = '0; d = '0; a[0] = AW'(7);
        o[0] = 3'd1; d[0] = 16'h55; push(4'b0001, a, o, d);
        o[0] = 3'd0; d[0] = 16'h00; push(4'b0001, a, o, d);
        o[0] = 3'd6; d[0] = 16'h0F; push(4'b0001, a, o, d);
        o[0] = 3'd0; d[0] = 16'h00; push(4'b0001, a, o, d);
        for (int v = 0; v < 4; v++) begin
            pop(gm, gd);
            check(gd[0] == DW'(exp_v[v]), "R4", "same-lane order reply", int'(gd[0]), exp_v[v]);
        end
    endtask

    task automatic t_ops();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        int exp_v [4] = '{0, 50, 42, 40};
        a = '0; o = '0; d = '0; a[0] = AW'(8);
        o[0] = 3'd1; d[0] = 16'd50;   push(4'b0001, a, o, d);
        o[0] = 3'd3; d[0] = 16'd8;    push(4'b0001, a, o, d);
        o[0] = 3'd4; d[0] = 16'h3C;   push(4'b0001, a, o, d);
        o[0] = 3'd5; d[0] = 16'h01;   push(4'b0001, a, o, d);
        for (int v = 0; v < 4; v++) begin
            pop(gm, gd);
            check(gd[0] == DW'(exp_v[v]), "R3", "op prior value", int'(gd[0]), exp_v[v]);
        end
        o[0] = 3'd0; d[0] = '0; push(4'b0001, a, o, d);
        pop(gm, gd);
        check(gd[0] == 16'h29, "R3", "op chain result", int'(gd[0]), 'h29);
    endtask

    task automatic t_mask();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o; logic [L-1:0][DW-1:0] d;
        a[0] = AW'(16); a[1] = AW'(9); a[2] = AW'(20); a[3] = AW'(13);
        d[0] = 16'd1;   d[1] = 16'd77; d[2] = 16'd2;   d[3] = 16'd88;
        for (int l = 0; l < L; l++) o[l] = 3'd1;
        push(4'b0101, a, o, d);
        pop(gm, gd);
        check(gm == 4'b0101, "R9", "delivered mask", int'(gm), 5);
        check(gd[1] == 0, "R9", "masked lane1 data", int'(gd[1]), 0);
        check(gd[3] == 0, "R9", "masked lane3 data", int'(gd[3]), 0);
        for (int l = 0; l < L; l++) o[l] = 3'd0;
        push(4'b1111, a, o, '0);
        pop(gm, gd);
        check(gd[0] == 1, "R9", "active lane0 stored", int'(gd[0]), 1);
        check(gd[1] == 0, "R9", "masked lane1 left memory", int'(gd[1]), 0);
        check(gd[2] == 2, "R9", "active lane2 stored", int'(gd[2]), 2);
        check(gd[3] == 0, "R9", "masked lane3 left memory", int'(gd[3]), 0);
    endtask

    task automatic t_full();
        logic [L-1:0][AW-1:0] a; logic [L-1:0][2:0] o;
        logic [DW-1:0] held;
        o = '0;
        for (int v = 0; v < D; v++) begin a = '0; a[0] = AW'(v); push(4'b0001, a, o, '0); end
        @(negedge clk);
        a = '0; a[0] = AW'(3);
        in_valid = 1'b1; in_lane_vld = 4'b0001; in_addr = a; in_op = o;
        repeat (5) @(negedge clk);
        check(in_ready == 1'b0, "R10", "in_ready when full", int'(in_ready), 0);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R11", "valid while stalled", int'(out_valid), 1);
        held = out_data[0];
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1 && out_data[0] == held, "R11", "held data", int'(out_data[0]), int'(held));
        for (int v = 0; v < D; v++) begin
            pop(gm, gd);
            check(gd[0] == DW'(100 + v), "R8", "dequeue order", int'(gd[0]), 100 + v);
        end
        repeat (6) @(negedge clk);
        check(out_valid == 1'b0, "R10", "refused vector not taken", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_dense();
        t_conflict();
        t_forward();
        t_oldest();
        t_ops();
        t_mask();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule